// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block drives the indirect register port of a PHY. The PHY exposes a 16-bit bus and four strobes, and it answers each strobe with a single acknowledge bit. A client asks for one register access by giving an address, a read/write select, write data and a one-cycle start. The block then runs the whole strobe-and-acknowledge sequence on its own. When the access ends it gives a one-cycle done, an error flag and, for a read, the 16-bit value the PHY returned.

Every step of an access is a complete four-phase exchange. The block raises a strobe and waits for the acknowledge to go high. It then drops the strobe and waits for the acknowledge to go low. The address is latched by its own capture strobe, and so is the write data. Only after that does the block raise a separate write or read strobe. The block checks the acknowledge only at poll instants spaced `PRESCALE` clock cycles apart. It allows `POLLS` polls per wait. If the expected level never appears, the access is abandoned and reported as an error.

Top module: `phy_cport_master`

## Requirements
- R1: While reset is held, and after reset until the first start, the bus and all four strobes are 0, busy, done and error are 0, and read data is 0.
- R2: Every access opens with an address phase. The address appears on the bus with no strobe for one cycle. Then capture-address is raised with the address still on the bus until the acknowledge is seen high. Then capture-address is dropped with the address held until the acknowledge is seen low.
- R3: A write follows the address phase with a data phase of the same shape that uses capture-data. It then raises the write strobe with the bus at 0 until the acknowledge is high. Next it drops the strobe with the data back on the bus until the acknowledge is low, and it ends with every port output at 0.
- R4: A read follows the address phase by raising the read strobe alone with the bus at 0. On the poll that sees the acknowledge high, it takes the PHY read data as its result. It then drives every port output to 0 and waits for the acknowledge to go low.
- R5: No two strobes are ever high in the same cycle, and the bus is 0 whenever the write or read strobe is high.
- R6: The acknowledge is polled on the first cycle of each wait step and then every `PRESCALE` cycles, at most `POLLS` times. An acknowledge that first shows up on the last poll still completes the step.
- R7: If a wait step has not seen its level by its last poll, that step lasts (`POLLS`-1)·`PRESCALE`+1 cycles. The next cycle has done and error both high, busy low, and every port output at 0.
- R8: A start that arrives while busy is high is ignored. It neither changes the access in progress nor queues a new one.
- R9: Read data changes only when a read completes successfully. A write or a failed access leaves it unchanged.
- R10: Done is high for exactly one cycle, and busy is low in that cycle. A start presented in the done cycle is accepted, and busy is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Begin an access (taken when busy is low) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Data for a write |
| req_busy | output | 1 | An access is in progress |
| req_done | output | 1 | One-cycle end-of-access pulse |
| req_rdata | output | 16 | Result of the last successful read |
| req_error | output | 1 | High with done when an acknowledge wait timed out |
| phy_bus | output | 16 | Address/data bus to the PHY port |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_wr | output | 1 | Write strobe |
| phy_rd | output | 1 | Read strobe |
| phy_ack | input | 1 | Acknowledge from the PHY |
| phy_rdata | input | 16 | Read data from the PHY |

## Verification
The sharpest collision is an acknowledge arriving on the very poll where the step would otherwise time out. Success and timeout are then decided in the same cycle. The bench's PHY model delays its acknowledge by a programmable number of cycles, placing the arrival exactly on the last poll and then one cycle after it. The first case must finish without error and return the stored value. The second must give done with error after the exact timeout length.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  localparam int PHY_DW = 16;

  // Bit order matters: the port word is {rd, wr, cap_dat, cap_adr, bus[15:0]}.
  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              cap_dat;
    logic              cap_adr;
    logic [PHY_DW-1:0] bus;
  } ctl_word_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_PRES,
    ST_A_CAP,
    ST_A_REL,
    ST_D_PRES,
    ST_D_CAP,
    ST_D_REL,
    ST_W_STB,
    ST_W_REL,
    ST_R_STB,
    ST_R_REL,
    ST_DONE
  } step_e;

  // Steps that wait for an acknowledge level.
  function automatic logic is_wait_step(step_e s);
    return s inside {ST_A_CAP, ST_A_REL, ST_D_CAP, ST_D_REL,
                     ST_W_STB, ST_W_REL, ST_R_STB, ST_R_REL};
  endfunction

  // Acknowledge level a wait step is looking for.
  function automatic logic wanted_ack(step_e s);
    return s inside {ST_A_CAP, ST_D_CAP, ST_W_STB, ST_R_STB};
  endfunction

  // Successor of a step once it completes.
  function automatic step_e step_after(step_e s, logic is_wr);
    step_e n;
    case (s)
      ST_A_PRES: n = ST_A_CAP;
      ST_A_CAP:  n = ST_A_REL;
      ST_A_REL:  n = is_wr ? ST_D_PRES : ST_R_STB;
      ST_D_PRES: n = ST_D_CAP;
      ST_D_CAP:  n = ST_D_REL;
      ST_D_REL:  n = ST_W_STB;
      ST_W_STB:  n = ST_W_REL;
      ST_W_REL:  n = ST_DONE;
      ST_R_STB:  n = ST_R_REL;
      ST_R_REL:  n = ST_DONE;
      default:   n = ST_IDLE;
    endcase
    return n;
  endfunction

  // Port word driven during a step.
  function automatic ctl_word_t word_for(step_e s, logic [PHY_DW-1:0] adr,
                                         logic [PHY_DW-1:0] dat);
    ctl_word_t w;
    w = '0;
    case (s)
      ST_A_PRES, ST_A_REL:           w.bus = adr;
      ST_A_CAP: begin
        w.bus     = adr;
        w.cap_adr = 1'b1;
      end
      ST_D_PRES, ST_D_REL, ST_W_REL: w.bus = dat;
      ST_D_CAP: begin
        w.bus     = dat;
        w.cap_dat = 1'b1;
      end
      ST_W_STB:                      w.wr = 1'b1;
      ST_R_STB:                      w.rd = 1'b1;
      default:                       w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/physeq_poll_timer.sv
module physeq_poll_timer #(
  parameter int PRESCALE = 4,
  parameter int POLLS    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic active_i,
  output logic poll_o,
  output logic last_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int PW = $clog2(POLLS + 1);
  localparam logic [CW-1:0] CYC_TOP  = CW'(PRESCALE - 1);
  localparam logic [PW-1:0] POLL_TOP = PW'(POLLS - 1);
  localparam logic [PW-1:0] POLL_MAX = PW'(POLLS);

  logic [CW-1:0] cyc_q;
  logic [PW-1:0] polls_q;

  assign poll_o = active_i && (cyc_q == '0) && (polls_q < POLL_MAX);
  assign last_o = (polls_q == POLL_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      cyc_q   <= '0;
      polls_q <= '0;
    end else if (active_i) begin
      cyc_q <= (cyc_q == CYC_TOP) ? '0 : cyc_q + 1'b1;
      if (poll_o) polls_q <= polls_q + 1'b1;
    end
  end

  a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (polls_q <= POLL_MAX));

  generate
    if (PRESCALE > 1) begin : g_spacing
      a_r6_poll_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_o && !clear_i) |=> !poll_o);
    end
  endgenerate
endmodule

// File: rtl/physeq_rd_hold.sv
module physeq_rd_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      dout_o <= '0;
    else if (take_i) dout_o <= din_i;
  end
endmodule

// File: rtl/physeq_step_fsm.sv
module physeq_step_fsm
  import physeq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [PHY_DW-1:0] addr_i,
  input  logic [PHY_DW-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              poll_i,
  input  logic              last_poll_i,
  output logic              adv_o,
  output logic              wait_o,
  output logic              take_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output ctl_word_t         ctl_o
);
  step_e             st_q, st_d;
  logic              wr_q, err_q;
  logic [PHY_DW-1:0] addr_q, wdata_q;
  logic              accept, timeout_ev, step_hit;

  assign busy_o  = !(st_q inside {ST_IDLE, ST_DONE});
  assign done_o  = (st_q == ST_DONE);
  assign error_o = done_o && err_q;
  assign wait_o  = is_wait_step(st_q);
  assign accept  = start_i && !busy_o;
  assign ctl_o   = word_for(st_q, addr_q, wdata_q);

  assign step_hit   = wait_o && poll_i && (ack_i == wanted_ack(st_q));
  assign timeout_ev = wait_o && poll_i && !step_hit && last_poll_i;
  assign take_o     = step_hit && (st_q == ST_R_STB);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_DONE: st_d = accept ? ST_A_PRES : ST_IDLE;
      ST_A_PRES, ST_D_PRES: st_d = step_after(st_q, wr_q);
      default: begin
        if (step_hit)        st_d = step_after(st_q, wr_q);
        else if (timeout_ev) st_d = ST_DONE;
      end
    endcase
  end

  assign adv_o = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        wr_q    <= write_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        err_q   <= 1'b0;
      end else if (timeout_ev) begin
        err_q <= 1'b1;
      end
    end
  end

  a_r8_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(addr_q) && $stable(wdata_q) && $stable(wr_q)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: rtl/phy_cport_master.sv
module phy_cport_master
  import physeq_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int POLLS    = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        req_busy,
  output logic        req_done,
  output logic [15:0] req_rdata,
  output logic        req_error,
  output logic [15:0] phy_bus,
  output logic        phy_cap_addr,
  output logic        phy_cap_data,
  output logic        phy_wr,
  output logic        phy_rd,
  input  logic        phy_ack,
  input  logic [15:0] phy_rdata
);
  ctl_word_t ctl;
  logic      step_adv, in_wait, poll_now, last_poll, take_rd;

  physeq_step_fsm i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (req_start),
    .write_i     (req_write),
    .addr_i      (req_addr),
    .wdata_i     (req_wdata),
    .ack_i       (phy_ack),
    .poll_i      (poll_now),
    .last_poll_i (last_poll),
    .adv_o       (step_adv),
    .wait_o      (in_wait),
    .take_o      (take_rd),
    .busy_o      (req_busy),
    .done_o      (req_done),
    .error_o     (req_error),
    .ctl_o       (ctl)
  );

  physeq_poll_timer #(.PRESCALE(PRESCALE), .POLLS(POLLS)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (step_adv),
    .active_i (in_wait),
    .poll_o   (poll_now),
    .last_o   (last_poll)
  );

  physeq_rd_hold #(.W(PHY_DW)) i_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take_rd),
    .din_i  (phy_rdata),
    .dout_o (req_rdata)
  );

  assign phy_bus      = ctl.bus;
  assign phy_cap_addr = ctl.cap_adr;
  assign phy_cap_data = ctl.cap_dat;
  assign phy_wr       = ctl.wr;
  assign phy_rd       = ctl.rd;

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}));

  a_r5_strobe_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_wr || phy_rd) |-> (phy_bus == '0));

  a_r2_addr_presented_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_cap_addr) |-> ($past(phy_bus) == phy_bus));

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (phy_bus == '0 && !phy_cap_addr && !phy_cap_data &&
                  !phy_wr && !phy_rd && !req_busy));

  a_r7_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    req_error |-> req_done);

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_busy |=> $stable(req_rdata));
endmodule

// File: tb/test_phy_cport_master.sv
module test_phy_cport_master;
  localparam int CLK_P    = 10;
  localparam int PRESCALE = 4;
  localparam int POLLS    = 10;
  localparam int TO_STEP  = (POLLS - 1) * PRESCALE + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_busy, req_done, req_error;
  logic [15:0] req_rdata;
  logic [15:0] phy_bus, phy_rdata;
  logic        phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_ack;

  int total = 0;
  int bad   = 0;
  int multi_strobe = 0;
  int strobe_bus   = 0;

  always #(CLK_P/2) clk = ~clk;

  phy_cport_master #(.PRESCALE(PRESCALE), .POLLS(POLLS)) i_phy_cport_master (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_busy(req_busy),
    .req_done(req_done), .req_rdata(req_rdata), .req_error(req_error),
    .phy_bus(phy_bus), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
    .phy_wr(phy_wr), .phy_rd(phy_rd), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  // PHY model: 16 registers, acknowledge delayed by 'lat' cycles.
  // mode 0 = normal, 1 = acknowledge stuck low, 2 = acknowledge stuck high.
  logic [15:0] mem [16];
  logic [15:0] m_addr, m_data;
  logic [3:0]  prev_stb;
  logic [63:0] pipe;
  int          lat  = 1;
  int          mode = 0;
  wire any_stb = phy_cap_addr | phy_cap_data | phy_wr | phy_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
      m_addr   <= '0;
      m_data   <= '0;
      prev_stb <= '0;
      pipe     <= '0;
    end else begin
      pipe     <= {pipe[62:0], any_stb};
      prev_stb <= {phy_cap_addr, phy_cap_data, phy_wr, phy_rd};
      if (phy_cap_addr && !prev_stb[3]) m_addr <= phy_bus;
      if (phy_cap_data && !prev_stb[2]) m_data <= phy_bus;
      if (phy_wr && !prev_stb[1])       mem[m_addr[3:0]] <= m_data;
    end
  end

  always_comb begin
    if (mode == 1)      phy_ack = 1'b0;
    else if (mode == 2) phy_ack = 1'b1;
    else                phy_ack = pipe[lat-1];
  end
  assign phy_rdata = mem[m_addr[3:0]];

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}) > 1) multi_strobe++;
      if ((phy_wr || phy_rd) && phy_bus != '0) strobe_bus++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs one access; returns at the negedge where done is high.
  task automatic xfer(input logic wr, input logic [15:0] a, input logic [15:0] d,
                      output int bc, output logic er, output logic [15:0] rd);
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    bc = 0;
    while (!req_done && bc < 3000) begin
      if (req_busy) bc++;
      @(negedge clk);
    end
    if (!req_done) chk(1'b0, "xfer never finished", 0, 1);
    er = req_error;
    rd = req_rdata;
  endtask

  task automatic t_reset;
    chk(phy_bus == 0 && !phy_cap_addr && !phy_cap_data && !phy_wr && !phy_rd,
        "R1 port outputs", {phy_rd, phy_wr, phy_cap_data, phy_cap_addr, phy_bus}, 0);
    chk(!req_busy && !req_done && !req_error, "R1 status",
        {req_busy, req_done, req_error}, 0);
    chk(req_rdata == 0, "R1 rdata", req_rdata, 0);
  endtask

  task automatic t_write_read;
    int bc; logic er; logic [15:0] rd;
    lat = 1; mode = 0;
    xfer(1'b1, 16'h1005, 16'hA5C3, bc, er, rd);
    chk(!er, "R3 write error", er, 0);
    chk(bc == 32, "R6 write busy cycles", bc, 32);
    chk(m_addr == 16'h1005, "R2 captured address", m_addr, 16'h1005);
    chk(mem[5] == 16'hA5C3, "R3 stored data", mem[5], 16'hA5C3);
    chk(phy_bus == 0, "R3 bus zero at end", phy_bus, 0);
    idle(4);
    xfer(1'b0, 16'h1005, 16'h0, bc, er, rd);
    chk(!er && rd == 16'hA5C3, "R4 read back", rd, 16'hA5C3);
    chk(bc == 21, "R6 read busy cycles", bc, 21);
    idle(4);
    xfer(1'b1, 16'h100D, 16'h0001, bc, er, rd);
    idle(4);
    xfer(1'b0, 16'h100D, 16'h0, bc, er, rd);
    chk(rd == 16'h0001, "R4 second pattern", rd, 16'h0001);
    idle(4);
  endtask

  task automatic t_start_ignored;
    int bc; logic er; logic [15:0] rd;
    xfer(1'b1, 16'h0003, 16'h1111, bc, er, rd);
    idle(4);
    // new write, with a competing start pulsed mid-access
    @(negedge clk);
    req_write = 1'b1; req_addr = 16'h0003; req_wdata = 16'h2B2B; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    idle(5);
    req_addr = 16'h0004; req_wdata = 16'h2222; req_start = 1'b1;
    idle(3);
    req_start = 1'b0;
    bc = 0;
    while (!req_done && bc < 3000) begin bc++; @(negedge clk); end
    @(negedge clk);
    chk(!req_busy, "R8 no queued access", req_busy, 0);
    idle(4);
    xfer(1'b0, 16'h0004, 16'h0, bc, er, rd);
    chk(rd == 16'h0000, "R8 reg4 untouched", rd, 0);
    idle(4);
    xfer(1'b0, 16'h0003, 16'h0, bc, er, rd);
    chk(rd == 16'h2B2B, "R8 first access intact", rd, 16'h2B2B);
    idle(4);
  endtask

  task automatic t_hold;
    int bc; logic er; logic [15:0] rd;
    xfer(1'b1, 16'h0007, 16'h7777, bc, er, rd);
    chk(rd == 16'h2B2B, "R9 write keeps rdata", rd, 16'h2B2B);
    idle(6);
    chk(req_rdata == 16'h2B2B, "R9 rdata held idle", req_rdata, 16'h2B2B);
  endtask

  task automatic t_timeouts;
    int bc; logic er; logic [15:0] rd;
    mode = 1;
    xfer(1'b0, 16'h0007, 16'h0, bc, er, rd);
    chk(er == 1'b1, "R7 dead ack error", er, 1);
    chk(bc == TO_STEP + 1, "R7 dead ack duration", bc, TO_STEP + 1);
    chk(!req_busy && phy_bus == 0 && !phy_cap_addr, "R7 quiet at done",
        {req_busy, phy_cap_addr, phy_bus}, 0);
    chk(rd == 16'h2B2B, "R9 failed read keeps rdata", rd, 16'h2B2B);
    @(negedge clk);
    chk(!req_done && !req_error, "R10 done one cycle", {req_done, req_error}, 0);
    mode = 2;
    idle(3);
    xfer(1'b1, 16'h0008, 16'h8888, bc, er, rd);
    chk(er == 1'b1, "R7 stuck ack error", er, 1);
    chk(bc == TO_STEP + 2, "R7 stuck ack duration", bc, TO_STEP + 2);
    mode = 0; lat = 1;
    idle(80);
  endtask

  task automatic t_last_poll;
    int bc; logic er; logic [15:0] rd;
    lat = TO_STEP - 1;  // ack seen exactly on the last poll
    xfer(1'b0, 16'h0007, 16'h0, bc, er, rd);
    chk(!er, "R6 ack on last poll succeeds", er, 0);
    chk(rd == 16'h7777, "R6 last poll data", rd, 16'h7777);
    idle(80);
    lat = TO_STEP;      // one cycle too late
    xfer(1'b0, 16'h0003, 16'h0, bc, er, rd);
    chk(er == 1'b1, "R7 ack one cycle late", er, 1);
    chk(bc == TO_STEP + 1, "R7 late ack duration", bc, TO_STEP + 1);
    lat = 1;
    idle(80);
  endtask

  task automatic t_back_to_back;
    int n;
    @(negedge clk);
    req_write = 1'b0; req_addr = 16'h0003; req_start = 1'b1;
    n = 0;
    @(negedge clk);
    while (!req_done && n < 3000) begin n++; @(negedge clk); end
    chk(req_done && !req_busy, "R10 done without busy", {req_done, req_busy}, 2'b10);
    chk(req_rdata == 16'h2B2B, "R4 first of pair", req_rdata, 16'h2B2B);
    @(negedge clk);
    req_start = 1'b0;
    chk(req_busy && !req_done, "R10 start taken on done", {req_busy, req_done}, 2'b10);
    n = 0;
    while (!req_done && n < 3000) begin n++; @(negedge clk); end
    chk(!req_error && req_rdata == 16'h2B2B, "R10 second access", req_rdata, 16'h2B2B);
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_write_read;
    t_start_ignored;
    t_hold;
    t_timeouts;
    t_last_poll;
    t_back_to_back;
    chk(multi_strobe == 0, "R5 single strobe", multi_strobe, 0);
    chk(strobe_bus == 0, "R5 bus zero under strobe", strobe_bus, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule